// File: doc/BRIEF.md
# Four-Slot Wait-Free Word Exchange

This block hands data words from a single producer to a single consumer without either side ever blocking the other. Storage is four word slots arranged as two pairs of two. Three shared control bits steer every access. The first records the pair the consumer has claimed. The second records the pair most recently completed by the producer. The third is a two-entry table that names, for each pair, the slot that holds that pair's newest word.

Each side runs a fixed five-step sequence, one step per clock, in any interleaving with the other side. The producer claims the pair the consumer is not reading, picks the slot in that pair that is not currently published, stores the word, publishes the slot, and then marks the pair as latest. The consumer samples the latest pair, claims it, looks up its published slot, fetches the word, and returns it. The consumer therefore always receives a word that was written whole.

The write side is a valid/ready input. A word is taken on a clock edge where `wr_valid` and `wr_ready` are both high, and `wr_ready` stays low while the sequence runs. The read side is a request/ready input with a one-cycle result pulse. The result has no back-pressure: the consumer must take `rd_data` in the cycle `rd_valid` is high.

Top module: `fourslot_xchg`

## Requirements
- R1: After reset both `wr_ready` and `rd_ready` are high, `rd_valid` is low, and a read made before any write returns an all-zero word.
- R2: A write is accepted on a rising edge where `wr_valid` and `wr_ready` are high. `wr_ready` is then low for exactly five cycles. `wr_valid` presented while `wr_ready` is low is ignored, and its word is never returned.
- R3: A read is accepted on a rising edge where `rd_req` and `rd_ready` are high. `rd_valid` is high for exactly one cycle, the fifth cycle after the accepting edge, together with `rd_data`. `rd_ready` is low until then. `rd_req` presented while `rd_ready` is low produces no extra pulse.
- R4: A read accepted five or more cycles after a write was accepted, with no newer write, returns that write's word.
- R5: In any cycle where the producer stores a word and the consumer fetches one, the two address different slots (pair or index differ). The producer's chosen index always differs from the pair's currently published index.
- R6: A read whose sequence overlaps a write returns either the previously completed word or the new word, never anything else. This holds when latest=1 and reading=0 and the producer picks its pair one cycle before the consumer samples latest.
- R7: A write accepted one cycle before a read, in the same cycle as the read, or later, does not affect that read, which returns the previously completed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Producer offers a word |
| wr_ready | output | 1 | Producer sequence idle; offer is taken |
| wr_data | input | DATA_W | Word to store |
| rd_req | input | 1 | Consumer asks for the latest word |
| rd_ready | output | 1 | Consumer sequence idle; request is taken |
| rd_valid | output | 1 | One-cycle pulse marking returned word |
| rd_data | output | DATA_W | Returned word, valid with rd_valid |

## Verification
A write accepted at edge k holds `wr_ready` low until edge k+5. A read accepted at edge k drives `rd_valid` in the cycle after edge k+4, and no earlier or later. The bench drives every request on a falling edge and samples on the next falling edges, counting edges so that it checks the pulse at exactly the fifth sample after the request. Sweeps move the write's acceptance from seven cycles before to seven cycles after the read's acceptance, over several starting states of the control bits. For each offset the bench decides by cycle arithmetic whether the old word, the new word, or either is due.

// File: rtl/fs_pkg.sv
package fs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_S1   = 3'd1,
    ST_S2   = 3'd2,
    ST_S3   = 3'd3,
    ST_S4   = 3'd4,
    ST_S5   = 3'd5
  } step_e;

  function automatic step_e next_step(input step_e s);
    case (s)
      ST_S1:   return ST_S2;
      ST_S2:   return ST_S3;
      ST_S3:   return ST_S4;
      ST_S4:   return ST_S5;
      default: return ST_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/fs_store.sv
module fs_store
  import fs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arr_we,
  input  logic              arr_pair,
  input  logic              arr_idx,
  input  logic [DATA_W-1:0] arr_word,
  input  logic              tab_we,
  input  logic              tab_pair,
  input  logic              tab_val,
  input  logic              last_we,
  input  logic              last_val,
  input  logic              claim_we,
  input  logic              claim_val,
  input  logic              fetch_pair,
  input  logic              fetch_idx,
  output logic [DATA_W-1:0] fetch_word,
  output logic              claim_q,
  output logic              last_q,
  output logic [1:0]        tab_q
);
  localparam int NPAIR = 2;
  localparam int NIDX  = 2;

  logic [DATA_W-1:0] mem [NPAIR][NIDX];

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    for (genvar i = 0; i < NIDX; i++) begin : g_idx
      always_ff @(posedge clk) begin
        if (!rst_n)
          mem[p][i] <= '0;
        else if (arr_we && arr_pair == p[0] && arr_idx == i[0])
          mem[p][i] <= arr_word;
      end
    end
    always_ff @(posedge clk) begin
      if (!rst_n)
        tab_q[p] <= 1'b0;
      else if (tab_we && tab_pair == p[0])
        tab_q[p] <= tab_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      claim_q <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      if (claim_we) claim_q <= claim_val;
      if (last_we)  last_q  <= last_val;
    end
  end

  assign fetch_word = mem[fetch_pair][fetch_idx];

  AST_SLOT_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    tab_we |-> (tab_val != tab_q[tab_pair])); // R5
endmodule

// File: rtl/fs_writer.sv
module fs_writer
  import fs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              claim_q,
  input  logic [1:0]        tab_q,
  output logic              arr_we,
  output logic              tab_we,
  output logic              last_we,
  output logic              w_pair,
  output logic              w_idx,
  output logic [DATA_W-1:0] w_word
);
  step_e st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      w_pair <= 1'b0;
      w_idx  <= 1'b0;
      w_word <= '0;
    end else begin
      case (st)
        ST_IDLE: if (wr_valid) begin
          w_word <= wr_data;
          st     <= ST_S1;
        end
        ST_S1: begin
          w_pair <= ~claim_q;
          st     <= next_step(st);
        end
        ST_S2: begin
          w_idx <= ~tab_q[w_pair];
          st    <= next_step(st);
        end
        default: st <= next_step(st);
      endcase
    end
  end

  assign wr_ready = (st == ST_IDLE);
  assign arr_we   = (st == ST_S3);
  assign tab_we   = (st == ST_S4);
  assign last_we  = (st == ST_S5);

  AST_WR_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !wr_ready); // R2
  AST_WR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    last_we |=> wr_ready); // R2
endmodule

// File: rtl/fs_reader.sv
module fs_reader
  import fs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  output logic              rd_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              last_q,
  input  logic [1:0]        tab_q,
  input  logic [DATA_W-1:0] fetch_word,
  output logic              claim_we,
  output logic              fetching,
  output logic              r_pair,
  output logic              r_idx
);
  step_e st;
  logic [DATA_W-1:0] held;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      r_pair <= 1'b0;
      r_idx  <= 1'b0;
      held   <= '0;
    end else begin
      case (st)
        ST_IDLE: if (rd_req) st <= ST_S1;
        ST_S1: begin
          r_pair <= last_q;
          st     <= next_step(st);
        end
        ST_S3: begin
          r_idx <= tab_q[r_pair];
          st    <= next_step(st);
        end
        ST_S4: begin
          held <= fetch_word;
          st   <= next_step(st);
        end
        default: st <= next_step(st);
      endcase
    end
  end

  assign rd_ready = (st == ST_IDLE);
  assign claim_we = (st == ST_S2);
  assign fetching = (st == ST_S4);
  assign rd_valid = (st == ST_S5);
  assign rd_data  = held;

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_ready) |-> ##5 rd_valid); // R3
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R3
endmodule

// File: rtl/fourslot_xchg.sv
module fourslot_xchg
  import fs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  output logic              rd_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic              arr_we, tab_we, last_we, claim_we, fetching;
  logic              w_pair, w_idx, r_pair, r_idx;
  logic              claim_q, last_q;
  logic [1:0]        tab_q;
  logic [DATA_W-1:0] w_word, fetch_word;

  fs_writer #(.DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .claim_q(claim_q), .tab_q(tab_q),
    .arr_we(arr_we), .tab_we(tab_we), .last_we(last_we),
    .w_pair(w_pair), .w_idx(w_idx), .w_word(w_word)
  );

  fs_reader #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .rd_req(rd_req), .rd_ready(rd_ready),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .last_q(last_q), .tab_q(tab_q), .fetch_word(fetch_word),
    .claim_we(claim_we), .fetching(fetching),
    .r_pair(r_pair), .r_idx(r_idx)
  );

  fs_store #(.DATA_W(DATA_W)) u_st (
    .clk(clk), .rst_n(rst_n),
    .arr_we(arr_we), .arr_pair(w_pair), .arr_idx(w_idx), .arr_word(w_word),
    .tab_we(tab_we), .tab_pair(w_pair), .tab_val(w_idx),
    .last_we(last_we), .last_val(w_pair),
    .claim_we(claim_we), .claim_val(r_pair),
    .fetch_pair(r_pair), .fetch_idx(r_idx), .fetch_word(fetch_word),
    .claim_q(claim_q), .last_q(last_q), .tab_q(tab_q)
  );

  AST_COHERENT: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && fetching) |-> (w_pair != r_pair || w_idx != r_idx)); // R5
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (wr_ready && rd_ready && !rd_valid)); // R1
endmodule

// File: tb/sim_fourslot_xchg.sv
module sim_fourslot_xchg;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [DW-1:0] wr_data = '0;
  logic          rd_req = 1'b0;
  logic          rd_ready;
  logic          rd_valid;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  fourslot_xchg #(.DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_req(rd_req), .rd_ready(rd_ready),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Requests driven at falling edge n are taken at the following rising edge.
  task automatic run_window(input int tw, input int tr, input int rd_hold,
                            input logic [DW-1:0] wdat, input int len,
                            output logic [DW-1:0] got, output int vcount,
                            output int vfirst);
    got = '0; vcount = 0; vfirst = -1;
    for (int n = 0; n < len; n++) begin
      @(negedge clk);
      if (rd_valid) begin
        vcount++;
        if (vcount == 1) begin got = rd_data; vfirst = n; end
      end
      wr_valid = (n == tw);
      wr_data  = wdat;
      rd_req   = (tr >= 0) && (n >= tr) && (n < tr + rd_hold);
    end
    @(negedge clk);
    wr_valid = 1'b0;
    rd_req   = 1'b0;
  endtask

  task automatic do_write(input logic [DW-1:0] d);
    logic [DW-1:0] g; int c; int f;
    run_window(0, -1, 1, d, 8, g, c, f);
  endtask

  task automatic do_read(output logic [DW-1:0] g);
    int c; int f;
    run_window(-1, 0, 1, '0, 8, g, c, f);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [DW-1:0] g, a, b;
    int c, f;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: idle state and zero read
    check(wr_ready === 1'b1, "R1 wr_ready", {31'd0, wr_ready}, 32'd1);
    check(rd_ready === 1'b1, "R1 rd_ready", {31'd0, rd_ready}, 32'd1);
    check(rd_valid === 1'b0, "R1 rd_valid", {31'd0, rd_valid}, 32'd0);
    do_read(g);
    check(g === '0, "R1 read before write", g, '0);

    // R2: ready timing after acceptance
    @(negedge clk);
    wr_valid = 1'b1; wr_data = 32'h1234_5678;
    @(negedge clk);
    wr_valid = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      check(wr_ready === 1'b0, "R2 busy window", {31'd0, wr_ready}, 32'd0);
      @(negedge clk);
    end
    check(wr_ready === 1'b1, "R2 ready after five", {31'd0, wr_ready}, 32'd1);

    // R2: offer during busy ignored
    run_window(0, -1, 1, 32'hB0B0_0001, 3, g, c, f);
    wr_valid = 1'b1; wr_data = 32'hDEAD_0002;
    @(negedge clk);
    wr_valid = 1'b0;
    repeat (6) @(negedge clk);
    do_read(g);
    check(g === 32'hB0B0_0001, "R2 busy offer ignored", g, 32'hB0B0_0001);

    // R3: held request yields one pulse
    run_window(-1, 0, 5, '0, 14, g, c, f);
    check(c == 1, "R3 single pulse", c, 1);
    check(f == 5, "R3 pulse cycle", f, 5);
    check(g === 32'hB0B0_0001, "R4 repeat read", g, 32'hB0B0_0001);

    // Sweep write/read offsets over varied starting states (R3 R4 R6 R7)
    for (int p = 0; p < 4; p++) begin
      for (int d = -7; d <= 7; d++) begin
        int trial;
        trial = p * 16 + d + 8;
        a = 32'hA500_0000 + trial * 2;
        b = 32'h5A00_0000 + trial * 2 + 1;
        do_write(a);
        if (p[0]) begin
          do_read(g);
          check(g === a, "R4 read after write", g, a);
        end
        if (p[1]) begin
          a = a ^ 32'h0000_F000;
          do_write(a);
        end
        run_window(8 + d, 8, 1, b, 24, g, c, f);
        check(c == 1 && f == 13, "R3 sweep pulse", f, 13);
        if (d >= -1)
          check(g === a, "R7 old word kept", g, a);
        else if (d <= -5)
          check(g === b, "R4 fresh word", g, b);
        else
          check(g === a || g === b, "R6 whole word", g, b);
        do_read(g);
        check(g === b, "R4 settled", g, b);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule